// File: doc/BRIEF.md
# Serial Memory Bulk Erase Controller

This block is the command logic, on the slave side, of a serial memory that handles three instructions: write enable, bulk erase and read status. The serial clock, chip select and data input come in from the pins. They are synchronised into the system clock domain, and their edges are detected there. An 8-bit opcode is shifted in MSB first, sampled on rising serial clock edges as in SPI mode 0. A bit counter clears whenever chip select is high.

Write enable and bulk erase take effect only when chip select rises right after the eighth bit. A bulk erase is accepted when three conditions hold: the write enable latch is set, all four block-protect inputs are zero and no erase is in progress. It then starts a self-timed countdown of `T_BE` system clocks. During the countdown `erase_active` tells the memory array to fill with ones, and at the end `erase_done` pulses. While the erase runs, only the status read is honoured. The status byte is returned on falling serial clock edges for as long as chip select stays low.

Top module: `serial_erase_ctrl`

## Requirements
- R1: After reset `erase_active`, `erase_done` and `miso` are low, and a status read with `bp`=0 returns 00h.
- R2: A write enable (opcode 06h) that is followed by a chip-select rise right after its eighth bit, while no erase runs, sets the write enable latch.
- R3: Opcode 05h returns the status byte MSB first, with each bit driven after a falling serial clock edge. Bits 7:6 are 0, bits 5:2 are `bp[3:0]`, bit 1 is the write enable latch and bit 0 is write-in-progress.
- R4: A bulk erase (opcode C7h) sent while the write enable latch is clear is ignored.
- R5: A bulk erase sent while any `bp` bit is 1 is ignored, and the write enable latch keeps its value.
- R6: A bulk erase whose chip-select rise comes after 7 or 9 bits is ignored, and the write enable latch keeps its value.
- R7: An accepted bulk erase holds `erase_active` high for exactly `T_BE` system clock cycles.
- R8: Write-in-progress reads 1 during the erase and 0 afterwards. The write enable latch is cleared when the erase ends.
- R9: While an erase runs, every opcode except 05h is ignored. A second bulk erase neither restarts nor extends the countdown.
- R10: `erase_done` is a single-cycle pulse, given once for each erase, in the cycle in which `erase_active` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| bp | input | 4 | Block-protect bits, bp[3] is the top bit |
| miso | output | 1 | Serial data out, low when not reading status |
| erase_active | output | 1 | Array is being filled with ones |
| erase_done | output | 1 | One-cycle pulse at the end of the erase |

## Verification
The assertions check four rules on every cycle. An erase starts only from a set write enable latch and clear protect bits. The countdown falls by one on every busy cycle and never restarts. The latch stays set while busy. `erase_done` coincides with the fall of `erase_active`, and both status bits are clear at that point. The bench scenarios cover what needs whole serial transactions: the status byte layout and its bit timing, the rejection of misframed commands at 7 and 9 bits, the exact erase length, and the fact that a second bulk erase during the busy period has no effect.

// File: rtl/serial_erase_ctrl.sv
module serial_erase_ctrl #(
  parameter int T_BE = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  input  logic [3:0] bp,
  output logic       miso,
  output logic       erase_active,
  output logic       erase_done
);
  localparam int TW = (T_BE > 2) ? $clog2(T_BE) : 1;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_BE   = 8'hC7;
  localparam logic [7:0] OP_RDSR = 8'h05;

  logic [2:0]    sck_q, cs_q;
  logic [1:0]    mosi_q;
  logic [3:0]    cnt;
  logic [7:0]    sr, snap;
  logic [2:0]    ocnt;
  logic          rd, miso_q;
  logic          wel, wip, done_q;
  logic [TW-1:0] tmr;

  wire       sck_up = sck_q[1] & ~sck_q[2];
  wire       sck_dn = ~sck_q[1] & sck_q[2];
  wire       cs_hi  = cs_q[1];
  wire       cs_up  = cs_q[1] & ~cs_q[2];
  wire [7:0] nxt    = {sr[6:0], mosi_q[1]};
  wire [7:0] status = {2'b00, bp, wel, wip};
  wire       framed = cs_up && (cnt == 4'd8);
  wire       wren_ok = framed && (sr == OP_WREN) && !wip;
  wire       be_ok   = framed && (sr == OP_BE) && wel && (bp == 4'b0000) && !wip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 3'b000;
      cs_q   <= 3'b111;
      mosi_q <= 2'b00;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sr     <= '0;
      snap   <= '0;
      ocnt   <= '0;
      rd     <= 1'b0;
      miso_q <= 1'b0;
    end else if (cs_hi) begin
      cnt    <= '0;
      ocnt   <= '0;
      rd     <= 1'b0;
      miso_q <= 1'b0;
    end else begin
      if (sck_up) begin
        sr <= nxt;
        if (cnt != 4'd9) cnt <= cnt + 4'd1;
        if (cnt == 4'd7 && nxt == OP_RDSR) rd <= 1'b1;
      end
      if (sck_dn && rd) begin
        ocnt <= ocnt + 3'd1;
        if (ocnt == 3'd0) begin
          miso_q <= status[7];
          snap   <= status;
        end else begin
          miso_q <= snap[~ocnt];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel    <= 1'b0;
      wip    <= 1'b0;
      tmr    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (wip) begin
        if (tmr == '0) begin
          wip    <= 1'b0;
          wel    <= 1'b0;
          done_q <= 1'b1;
        end else begin
          tmr <= tmr - 1'b1;
        end
      end else if (be_ok) begin
        wip <= 1'b1;
        tmr <= TW'(T_BE - 1);
      end else if (wren_ok) begin
        wel <= 1'b1;
      end
    end
  end

  assign miso         = miso_q;
  assign erase_active = wip;
  assign erase_done   = done_q;
endmodule

// File: rtl/serial_erase_ctrl_chk.sv
module serial_erase_ctrl_chk #(
  parameter int T_BE = 1000,
  parameter int TW   = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    bp,
  input logic          wel,
  input logic          erase_active,
  input logic          erase_done,
  input logic [TW-1:0] tmr
);
  AST_START_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_active) |-> $past(wel)); // R4
  AST_START_PROT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_active) |-> ($past(bp) == 4'b0000)); // R5
  AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_active |-> (32'(tmr) <= T_BE - 1)); // R7
  AST_BUSY_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    erase_active |-> wel); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |-> (!wel && !erase_active)); // R8
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_active && $past(erase_active)) |-> (32'(tmr) == 32'($past(tmr)) - 1)); // R9
  AST_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_active) |-> erase_done); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |=> !erase_done); // R10
endmodule

bind serial_erase_ctrl serial_erase_ctrl_chk #(.T_BE(T_BE), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bp(bp), .wel(wel),
  .erase_active(erase_active), .erase_done(erase_done), .tmr(tmr)
);

// File: tb/serial_erase_ctrl_test.sv
`timescale 1ns/1ps
module serial_erase_ctrl_test;
  localparam int T_BE = 1000;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic [3:0] bp = 4'b0000;
  logic miso, erase_active, erase_done;

  int vectors = 0, fails = 0;
  int act_cnt = 0, done_cnt = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_on = 1'b0;
  logic [7:0] acc = '0;
  int         nbit = 0;

  always #2.5 clk = ~clk;

  serial_erase_ctrl #(.T_BE(T_BE)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .bp(bp),
    .miso(miso), .erase_active(erase_active), .erase_done(erase_done)
  );

  always @(posedge clk) begin
    if (erase_active) act_cnt <= act_cnt + 1;
    if (erase_done) done_cnt <= done_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge sck) begin
    if (rd_on) begin
      acc = {acc[6:0], miso};
      nbit++;
      if (nbit == 8) begin
        nbit = 0;
        if (exp_q.size() == 0) chk(1'b0, "scoreboard-empty", acc, 0);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(acc == e, t, acc, e);
        end
      end
    end
  end

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      mosi = v[15-i];
      #40 sck = 1'b1;
      #40 sck = 1'b0;
    end
  endtask

  task automatic cmd(input logic [15:0] v, input int n);
    cs_n = 1'b0;
    #40 send_bits(v, n);
    #40 cs_n = 1'b1;
    #200;
  endtask

  task automatic rdsr(input logic [7:0] e, input string tag, input int bytes);
    for (int b = 0; b < bytes; b++) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    cs_n = 1'b0;
    #40 send_bits(16'h0500, 8);
    rd_on = 1'b1;
    for (int i = 0; i < 8*bytes; i++) begin
      #40 sck = 1'b1;
      #40 sck = 1'b0;
    end
    rd_on = 1'b0;
    #40 cs_n = 1'b1;
    #200;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #102 rst_n = 1'b1;
    #50;
    chk(erase_active == 1'b0, "R1 erase_active", erase_active, 0);
    chk(erase_done == 1'b0, "R1 erase_done", erase_done, 0);
    chk(miso == 1'b0, "R1 miso idle", miso, 0);
    rdsr(8'h00, "R1 status after reset", 1);

    cmd(16'hC700, 8);
    chk(erase_active == 1'b0, "R4 no erase without latch", erase_active, 0);
    rdsr(8'h00, "R4 status", 1);

    cmd(16'h0600, 8);
    rdsr(8'h02, "R2 latch set", 1);

    bp = 4'b1010;
    rdsr(8'h2A, "R3 status layout", 2);

    bp = 4'b0100;
    cmd(16'hC700, 8);
    chk(erase_active == 1'b0, "R5 protected erase", erase_active, 0);
    rdsr(8'h12, "R5 latch kept", 1);

    bp = 4'b0000;
    cmd(16'hC700, 7);
    chk(erase_active == 1'b0, "R6 seven bits", erase_active, 0);
    rdsr(8'h02, "R6 latch kept after 7", 1);
    cmd(16'hC780, 9);
    chk(erase_active == 1'b0, "R6 nine bits", erase_active, 0);
    rdsr(8'h02, "R6 latch kept after 9", 1);
    chk(done_cnt == 0, "R10 no pulse yet", done_cnt, 0);

    cmd(16'hC700, 8);
    chk(erase_active == 1'b1, "R7 erase started", erase_active, 1);
    rdsr(8'h03, "R8 busy status", 1);
    cmd(16'hC700, 8);
    cmd(16'h0100, 8);
    begin
      int guard = 0;
      while (erase_active && guard < 5000) begin
        @(posedge clk);
        guard++;
      end
    end
    #20;
    chk(act_cnt == T_BE, "R7 R9 erase length", act_cnt, T_BE);
    chk(done_cnt == 1, "R10 done pulses", done_cnt, 1);
    rdsr(8'h00, "R8 idle status", 1);

    cmd(16'h0600, 8);
    rdsr(8'h02, "R2 latch after erase", 1);
    #100;
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    chk(miso == 1'b0, "R3 miso idle", miso, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule